// File: doc/BRIEF.md
# Synthesizer Loop and Output Divider Chain

This block holds the digital dividers that sit around a frequency-synthesizer PLL. It has three paths. A fixed stage divides the reference clock by sixteen before the phase detector sees it. A feedback path divides the VCO clock by a programmable 9-bit value M and then halves it, so the loop settles with the VCO at 2M times the divided reference. An output path divides the VCO clock by 1, 2, 4 or 8 with a 50% duty cycle.

The phase detector and the VCO are outside this block. The integrator wires `fb_clk` and `ref_div_out` to the phase detector, drives `vco_clk` from the oscillator, and takes `out_clk` to the output buffer. A new M or N value on the inputs takes effect only when the counter it affects reaches its terminal count, so a reprogramming never produces a runt pulse. An M outside the lock window is still divided exactly as given, and a separate flag reports it.

Top module: `pll_divider_chain`

## Requirements
- R1: `ref_div_out` is `ref_clk` divided by 16: a period of 16 reference cycles, high for 8 of them.
- R2: For an applied M of 2 or more, `fb_clk` has a period of 2M VCO cycles and stays high for M of them.
- R3: An applied M of 0 or 1 makes the M stage divide by 1, so `fb_clk` has a period of 2 VCO cycles.
- R4: The output select `n_sel` chooses the output ratio: 2'b00 divides by 2, 2'b01 by 4, 2'b10 by 8 and 2'b11 by 1.
- R5: For divide by 2, 4 and 8, `out_clk` is high for exactly half of each period.
- R6: With select 2'b11 applied, `out_clk` follows `vco_clk` level for level.
- R7: A new `m_div` is taken up only at the terminal count of the M counter. The feedback half-period that is running when M changes completes with the old value.
- R8: A new `n_sel` is taken up only when the 3-bit output counter wraps. An output high phase that is running when the select changes completes at its old length.
- R9: `m_range_err` is high while the applied M is below 125 or above 350, and low for 125 to 350 inclusive. Out-of-range values are still divided as given.
- R10: While `rst_n` is low, `ref_div_out` and `fb_clk` are low. The applied M is 511, so `m_range_err` is high. The applied select is 2'b11, so `out_clk` follows `vco_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock feeding the feedback and output dividers |
| ref_clk | input | 1 | Reference clock feeding the fixed divide-by-16 |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| m_div | input | 9 | Requested feedback divide value M |
| n_sel | input | 2 | Requested output ratio code |
| ref_div_out | output | 1 | Reference divided by 16, to the phase detector |
| fb_clk | output | 1 | VCO divided by 2M, to the phase detector |
| out_clk | output | 1 | Divided or bypassed VCO clock |
| m_range_err | output | 1 | Applied M lies outside the lock window |

## Verification
A new M reaches `fb_clk` at the first terminal count after it is driven. That is up to one old M-count later. The first rising edge of `fb_clk` after a change already belongs to the new value, so period and high time are counted from that edge onward, and the range flag is read at the same point. A new select reaches `out_clk` within 8 VCO cycles, so the bench waits 20 cycles before it measures. All levels are sampled 1 ns after the falling VCO edge, where every register has settled. The bypass check also samples after the rising edge. The two take-up checks drive the new value on the sample just after a rising output edge, then count the high samples of that pulse against the old length.

// File: rtl/pll_divider_chain.sv
module pll_divider_chain #(
  parameter int REF_W = 4,
  parameter int M_W   = 9,
  parameter int MIN_M = 125,
  parameter int MAX_M = 350
) (
  input  logic           vco_clk,
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_div,
  input  logic [1:0]     n_sel,
  output logic           ref_div_out,
  output logic           fb_clk,
  output logic           out_clk,
  output logic           m_range_err
);
  localparam int OUT_W = 3;
  localparam logic [M_W-1:0] M_LO = MIN_M[M_W-1:0];
  localparam logic [M_W-1:0] M_HI = MAX_M[M_W-1:0];
  localparam logic [M_W:0]   M_ONE = 1;
  localparam int REF_HALF = 2 ** (REF_W - 1);

  logic [REF_W-1:0] ref_cnt;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) ref_cnt <= '0;
    else        ref_cnt <= ref_cnt + 1'b1;
  assign ref_div_out = ref_cnt[REF_W-1];

  logic [M_W-1:0] m_cnt, m_act;
  logic           m_tc, fb_q;
  assign m_tc = ({1'b0, m_cnt} + M_ONE) >= {1'b0, m_act};

  always_ff @(posedge vco_clk or negedge rst_n)
    if (!rst_n) begin
      m_cnt <= '0;
      m_act <= '1;
      fb_q  <= 1'b0;
    end else if (m_tc) begin
      m_cnt <= '0;
      m_act <= m_div;
      fb_q  <= ~fb_q;
    end else begin
      m_cnt <= m_cnt + 1'b1;
    end
  assign fb_clk      = fb_q;
  assign m_range_err = (m_act < M_LO) || (m_act > M_HI);

  logic [OUT_W-1:0] o_cnt;
  logic [1:0]       n_act;
  logic             div_bit;
  always_ff @(posedge vco_clk or negedge rst_n)
    if (!rst_n) begin
      o_cnt <= '0;
      n_act <= 2'b11;
    end else begin
      o_cnt <= o_cnt + 1'b1;
      if (&o_cnt) n_act <= n_sel;
    end

  always_comb
    case (n_act)
      2'b00:   div_bit = o_cnt[0];
      2'b01:   div_bit = o_cnt[1];
      default: div_bit = o_cnt[2];
    endcase
  assign out_clk = (n_act == 2'b11) ? vco_clk : div_bit;

  logic [REF_W:0] ref_gap;
  logic           ref_q;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      ref_gap <= '0;
      ref_q   <= 1'b0;
    end else begin
      ref_q   <= ref_div_out;
      ref_gap <= (ref_div_out != ref_q) ? (REF_W+1)'(1) : ref_gap + 1'b1;
    end

  AST_REF_HALF: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ref_div_out != ref_q) |-> (ref_gap == (REF_W+1)'(REF_HALF))); // R1
  AST_FB_TOGGLE: assert property (@(posedge vco_clk) disable iff (!rst_n)
    m_tc |=> !$stable(fb_clk)); // R2
  AST_FB_STEADY: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !m_tc |=> $stable(fb_clk)); // R2
  AST_M_TAKEUP: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !$stable(m_act) |-> $past(m_tc)); // R7
  AST_N_TAKEUP: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !$stable(n_act) |-> (&$past(o_cnt))); // R8
endmodule

// File: tb/tb_pll_divider_chain.sv
module tb_pll_divider_chain;
  logic vco_clk = 0, ref_clk = 0, rst_n = 0;
  logic [8:0] m_div = 9'd100;
  logic [1:0] n_sel = 2'b11;
  logic ref_div_out, fb_clk, out_clk, m_range_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 vco_clk = ~vco_clk;
  always #10  ref_clk = ~ref_clk;

  pll_divider_chain dut (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .m_div(m_div), .n_sel(n_sel),
    .ref_div_out(ref_div_out), .fb_clk(fb_clk),
    .out_clk(out_clk), .m_range_err(m_range_err));

  // m, n, fb period, fb high, out period, out high, flag
  localparam int VEC [8][7] = '{
    '{125, 0, 250, 125, 2, 1, 0},
    '{350, 1, 700, 350, 4, 2, 0},
    '{124, 2, 248, 124, 8, 4, 1},
    '{351, 0, 702, 351, 2, 1, 1},
    '{2,   1, 4,   2,   4, 2, 1},
    '{1,   2, 2,   1,   8, 4, 1},
    '{0,   0, 2,   1,   2, 1, 1},
    '{200, 2, 400, 200, 8, 4, 0}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int sel);
    if (sel == 2) @(negedge ref_clk); else @(negedge vco_clk);
    #1;
  endtask

  function automatic logic sig(int sel);
    return (sel == 0) ? fb_clk : (sel == 1) ? out_clk : ref_div_out;
  endfunction

  task automatic meas(int sel, output int per, output int hi);
    logic p, c;
    p = 1'b1;
    while (1) begin tick(sel); c = sig(sel); if (!p && c) break; p = c; end
    per = 0; hi = 1; p = 1'b1;
    while (1) begin
      tick(sel); c = sig(sel); per++;
      if (!p && c) break;
      if (c) hi++;
      p = c;
    end
  endtask

  task automatic count_level(int sel, logic lvl, output int n);
    n = 0;
    while (sig(sel) == lvl) begin n++; tick(sel); end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, hi, n;
    repeat (3) @(negedge vco_clk);
    #1;
    check("R10 ref_div_out in reset", ref_div_out, 0);
    check("R10 fb_clk in reset", fb_clk, 0);
    check("R10 flag in reset", m_range_err, 1);
    check("R10 bypass low in reset", out_clk, 0);
    @(posedge vco_clk); #1;
    check("R10 bypass high in reset", out_clk, 1);
    @(negedge vco_clk); rst_n = 1;

    meas(2, per, hi);
    check("R1 ref period", per, 16);
    check("R1 ref high", hi, 8);

    for (int i = 0; i < 8; i++) begin
      @(negedge vco_clk);
      m_div = 9'(VEC[i][0]);
      n_sel = 2'(VEC[i][1]);
      meas(0, per, hi);
      check(VEC[i][0] < 2 ? "R3 fb period" : "R2 fb period", per, VEC[i][2]);
      check(VEC[i][0] < 2 ? "R3 fb high" : "R2 fb high", hi, VEC[i][3]);
      check("R9 range flag", m_range_err, VEC[i][6]);
      repeat (20) @(negedge vco_clk);
      meas(1, per, hi);
      check("R4 out period", per, VEC[i][4]);
      check("R5 out high", hi, VEC[i][5]);
    end

    // R7: M=200 applied; change to 10 just after a rise
    meas(0, per, hi);
    m_div = 9'd10;
    count_level(0, 1'b1, n);
    check("R7 old M finishes high phase", n, 200);
    count_level(0, 1'b0, n);
    check("R7 new M low phase", n, 10);

    // R8: divide by 8 running; switch to divide by 2 just after a rise
    meas(1, per, hi);
    n_sel = 2'b00;
    count_level(1, 1'b1, n);
    check("R8 old high phase kept", n, 4);
    count_level(1, 1'b0, n);
    check("R8 new low phase", n, 1);

    // R6: bypass
    n_sel = 2'b11;
    repeat (20) @(negedge vco_clk);
    for (int k = 0; k < 4; k++) begin
      @(posedge vco_clk); #1;
      check("R6 bypass high", out_clk, 1);
      @(negedge vco_clk); #1;
      check("R6 bypass low", out_clk, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule